// File: doc/BRIEF.md
# Alias-Mapped Atomic Single-Bit Writer

This block sits between one bus requester and the path to a backing memory. The backing memory has a small region of words. Every bit of every word in that region also has its own word-sized address in a separate alias window. A write to an alias address becomes a locked read-modify-write on the backing bus. The backing word is read, the one bit is set or cleared, and the word is written back. The lock stays asserted so that no other master can reach the word between the read and the write. Clients that each own one bit of a shared word can therefore claim or release that bit with a single store and no software lock. Afterwards they can read the backing word directly and see every owner's bit at once.

A read from an alias address returns the selected bit, zero-extended to a full word. Any address outside the alias window passes straight through as one ordinary transaction. The requester holds `s_valid` with stable fields until `s_done` pulses, and it drops `s_valid` in the cycle after that pulse. On the backing side, `m_valid` and its fields stay steady until `m_ack` is sampled high.

Top module: `bitalias_rmw`

## Requirements
- R1: An address A in the alias window [ALIAS_BASE, ALIAS_BASE + BACK_WORDS*DW*4) selects one bit of one backing word. With off = A - ALIAS_BASE, the bit index is (off/4) mod DW and the backing byte address is BACK_BASE + (off/(4*DW))*4. This gives DW consecutive alias words per backing word.
- R2: An alias write whose data bit 0 is 1 leaves the backing word with the selected bit at 1 and every other bit unchanged.
- R3: An alias write whose data bit 0 is 0 leaves the selected bit at 0 and every other bit unchanged. Bits DW-1..1 of the alias write data have no effect.
- R4: An alias write produces exactly two backing transactions, both at the same backing address: first a read, then a write. `m_lock` is high from the issue of the read until the write is acknowledged.
- R5: An alias read produces exactly one backing read with `m_lock` low. It returns the selected bit in `s_rdata[0]` with all other bits 0.
- R6: An access outside the alias window produces exactly one backing transaction with `m_lock` low. That transaction has the same address, direction and write data. A read returns `m_rdata` unchanged.
- R7: `s_done` is high for exactly one cycle per request. While a backing request is waiting for `m_ack`, its address, direction and valid stay stable.
- R8: While reset is held, `m_valid`, `m_lock` and `s_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Request pending from the requester |
| s_write | input | 1 | 1 = write, 0 = read |
| s_addr | input | AW | Request byte address |
| s_wdata | input | DW | Request write data |
| s_done | output | 1 | One-cycle completion pulse |
| s_rdata | output | DW | Read result, valid while s_done is high |
| m_valid | output | 1 | Backing bus request |
| m_write | output | 1 | Backing bus direction |
| m_lock | output | 1 | Backing bus lock, held across an atomic pair |
| m_addr | output | AW | Backing bus byte address |
| m_wdata | output | DW | Backing bus write data |
| m_ack | input | 1 | Backing bus acknowledge |
| m_rdata | input | DW | Backing bus read data |

## Verification
The bench sweeps every alias address of the default configuration. For each one it sets the bit, reads it back through the alias, and clears the bit for some of them. It compares the whole backing word with a model built from shifts and masks, so a wrong divisor in the address arithmetic or an off-by-one bit index shows up as the wrong word or bit changing. Alias write data carries junk in its upper bits, so a design that used the full data word instead of bit 0 would corrupt the neighbouring bits. Each request's backing transactions are logged under a varying acknowledge latency. This catches a lock dropped before the write acknowledge, a lock raised for plain or alias reads, and a write-back to a different address.

// File: rtl/bitalias_pkg.sv
package bitalias_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_MODWR = 2'd2,
    ST_RESP  = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    K_PASS_RD  = 2'd0,
    K_PASS_WR  = 2'd1,
    K_ALIAS_RD = 2'd2,
    K_ALIAS_WR = 2'd3
  } req_kind_e;

  // bit index selected by an alias byte offset: one alias word per bit
  function automatic int unsigned alias_bit_index(input int unsigned off,
                                                  input int unsigned dw);
    return (off >> 2) & (dw - 1);
  endfunction

  // byte offset of the backing word: dw alias words (4*dw bytes) per word
  function automatic int unsigned alias_word_byte(input int unsigned off,
                                                  input int unsigned log2_dw);
    return (off >> (2 + log2_dw)) << 2;
  endfunction

  function automatic req_kind_e classify(input logic hit, input logic wr);
    req_kind_e k;
    case ({hit, wr})
      2'b00:   k = K_PASS_RD;
      2'b01:   k = K_PASS_WR;
      2'b10:   k = K_ALIAS_RD;
      default: k = K_ALIAS_WR;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/bitalias_decode.sv
module bitalias_decode
  import bitalias_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned DW         = 32,
  parameter int unsigned BACK_BASE  = 32'h0000,
  parameter int unsigned BACK_WORDS = 8,
  parameter int unsigned ALIAS_BASE = 32'h2000
) (
  input  logic [AW-1:0]         addr,
  output logic                  hit,
  output logic [AW-1:0]         word_addr,
  output logic [$clog2(DW)-1:0] bit_idx
);
  localparam int unsigned LOG2_DW     = $clog2(DW);
  localparam int unsigned ALIAS_BYTES = BACK_WORDS * DW * 4;
  localparam int unsigned ALIAS_END   = ALIAS_BASE + ALIAS_BYTES;

  int unsigned a_full;
  int unsigned off;

  always_comb begin
    a_full = 32'(addr);
    hit    = (a_full >= ALIAS_BASE) && (a_full < ALIAS_END);
    off    = a_full - ALIAS_BASE;
    if (hit) begin
      word_addr = AW'(BACK_BASE + alias_word_byte(off, LOG2_DW));
      bit_idx   = LOG2_DW'(alias_bit_index(off, DW));
    end else begin
      word_addr = addr;
      bit_idx   = '0;
    end
  end

endmodule

// File: rtl/bitalias_merge.sv
module bitalias_merge #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0]         word,
  input  logic [$clog2(DW)-1:0] bit_idx,
  input  logic                  set_val,
  output logic [DW-1:0]         merged,
  output logic [DW-1:0]         picked
);
  logic [DW-1:0] sel_mask;

  always_comb begin
    sel_mask = '0;
    sel_mask[bit_idx] = 1'b1;
    merged = set_val ? (word | sel_mask) : (word & ~sel_mask);
    picked = '0;
    picked[0] = word[bit_idx];
  end

endmodule

// File: rtl/bitalias_seq.sv
module bitalias_seq
  import bitalias_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned DW         = 32,
  parameter int unsigned BACK_BASE  = 32'h0000,
  parameter int unsigned BACK_WORDS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s_valid,
  input  logic                  s_write,
  input  logic [AW-1:0]         s_addr,
  input  logic [DW-1:0]         s_wdata,
  output logic                  s_done,
  output logic [DW-1:0]         s_rdata,
  input  logic                  dec_hit,
  input  logic [AW-1:0]         dec_word_addr,
  input  logic [$clog2(DW)-1:0] dec_bit_idx,
  input  logic [DW-1:0]         mrg_word,
  input  logic [DW-1:0]         mrg_picked,
  output logic [DW-1:0]         held_word,
  output logic [$clog2(DW)-1:0] held_bit,
  output logic                  held_val,
  output logic                  m_valid,
  output logic                  m_write,
  output logic                  m_lock,
  output logic [AW-1:0]         m_addr,
  output logic [DW-1:0]         m_wdata,
  input  logic                  m_ack,
  input  logic [DW-1:0]         m_rdata
);
  localparam int unsigned LOG2_DW  = $clog2(DW);
  localparam int unsigned BACK_END = BACK_BASE + BACK_WORDS * 4;

  seq_state_e           state_q, state_d;
  req_kind_e            kind_q;
  logic [AW-1:0]        addr_q;
  logic [DW-1:0]        wdata_q;
  logic [DW-1:0]        word_q;
  logic [LOG2_DW-1:0]   bit_q;
  logic                 val_q;

  // named internal events, used by the assertions below
  logic ev_accept, ev_rd_ack, ev_wr_ack, ev_atomic;
  assign ev_accept = (state_q == ST_IDLE) && s_valid;
  assign ev_rd_ack = (state_q == ST_READ) && m_ack;
  assign ev_wr_ack = (state_q == ST_MODWR) && m_ack;
  assign ev_atomic = (kind_q == K_ALIAS_WR);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (s_valid)
                  state_d = (s_write && !dec_hit) ? ST_MODWR : ST_READ;
      ST_READ:  if (m_ack) state_d = ev_atomic ? ST_MODWR : ST_RESP;
      ST_MODWR: if (m_ack) state_d = ST_RESP;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= K_PASS_RD;
      addr_q  <= '0;
      wdata_q <= '0;
      word_q  <= '0;
      bit_q   <= '0;
      val_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_accept) begin
        kind_q  <= classify(dec_hit, s_write);
        addr_q  <= dec_word_addr;
        wdata_q <= s_wdata;
        bit_q   <= dec_bit_idx;
        val_q   <= s_wdata[0];
      end
      if (ev_rd_ack) word_q <= m_rdata;
    end
  end

  assign held_word = word_q;
  assign held_bit  = bit_q;
  assign held_val  = val_q;

  always_comb begin
    m_valid = (state_q == ST_READ) || (state_q == ST_MODWR);
    m_write = (state_q == ST_MODWR);
    m_lock  = m_valid && ev_atomic;
    m_addr  = addr_q;
    m_wdata = (state_q == ST_MODWR) ? (ev_atomic ? mrg_word : wdata_q) : '0;
    s_done  = (state_q == ST_RESP);
    case (kind_q)
      K_ALIAS_RD: s_rdata = s_done ? mrg_picked : '0;
      K_PASS_RD:  s_rdata = s_done ? word_q : '0;
      default:    s_rdata = '0;
    endcase
  end

  // R1: a decoded alias hit always lands on an aligned backing word in range
  p_map_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && dec_hit) |->
      (32'(dec_word_addr) >= BACK_BASE && 32'(dec_word_addr) < BACK_END &&
       dec_word_addr[1:0] == 2'b00));

  // R2, R3: the write-back differs from the fetched word in at most one bit
  p_one_bit_changed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_write && ev_atomic) |-> ($countones(m_wdata ^ word_q) <= 1));

  // R4: once raised, the lock holds until the write-back is acknowledged
  p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_lock && !ev_wr_ack) |=> m_lock);

  // R4: a locked write must follow a locked read at the same address
  p_lock_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_ack && ev_atomic |=> (m_lock && m_write && $stable(m_addr)));

  // R5, R6: reads and plain accesses never take the lock
  p_no_lock_plain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !ev_atomic) |-> !m_lock);

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_done |=> !s_done);

  // R7: an unacknowledged backing request holds steady
  p_req_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ack) |=> (m_valid && $stable(m_addr) && $stable(m_write)));

endmodule

// File: rtl/bitalias_rmw.sv
module bitalias_rmw
  import bitalias_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned DW         = 32,
  parameter int unsigned BACK_BASE  = 32'h0000,
  parameter int unsigned BACK_WORDS = 8,
  parameter int unsigned ALIAS_BASE = 32'h2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  input  logic          s_write,
  input  logic [AW-1:0] s_addr,
  input  logic [DW-1:0] s_wdata,
  output logic          s_done,
  output logic [DW-1:0] s_rdata,
  output logic          m_valid,
  output logic          m_write,
  output logic          m_lock,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic          m_ack,
  input  logic [DW-1:0] m_rdata
);
  localparam int unsigned LOG2_DW = $clog2(DW);

  logic               dec_hit;
  logic [AW-1:0]      dec_word_addr;
  logic [LOG2_DW-1:0] dec_bit_idx;
  logic [DW-1:0]      held_word, mrg_word, mrg_picked;
  logic [LOG2_DW-1:0] held_bit;
  logic               held_val;

  bitalias_decode #(
    .AW(AW), .DW(DW), .BACK_BASE(BACK_BASE),
    .BACK_WORDS(BACK_WORDS), .ALIAS_BASE(ALIAS_BASE)
  ) u_decode (
    .addr      (s_addr),
    .hit       (dec_hit),
    .word_addr (dec_word_addr),
    .bit_idx   (dec_bit_idx)
  );

  bitalias_merge #(.DW(DW)) u_merge (
    .word    (held_word),
    .bit_idx (held_bit),
    .set_val (held_val),
    .merged  (mrg_word),
    .picked  (mrg_picked)
  );

  bitalias_seq #(
    .AW(AW), .DW(DW), .BACK_BASE(BACK_BASE), .BACK_WORDS(BACK_WORDS)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .s_valid       (s_valid),
    .s_write       (s_write),
    .s_addr        (s_addr),
    .s_wdata       (s_wdata),
    .s_done        (s_done),
    .s_rdata       (s_rdata),
    .dec_hit       (dec_hit),
    .dec_word_addr (dec_word_addr),
    .dec_bit_idx   (dec_bit_idx),
    .mrg_word      (mrg_word),
    .mrg_picked    (mrg_picked),
    .held_word     (held_word),
    .held_bit      (held_bit),
    .held_val      (held_val),
    .m_valid       (m_valid),
    .m_write       (m_write),
    .m_lock        (m_lock),
    .m_addr        (m_addr),
    .m_wdata       (m_wdata),
    .m_ack         (m_ack),
    .m_rdata       (m_rdata)
  );

endmodule

// File: tb/bitalias_rmw_tb.sv
module bitalias_rmw_tb;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          s_valid = 1'b0, s_write = 1'b0;
  logic [AW-1:0] s_addr = '0;
  logic [DW-1:0] s_wdata = '0;
  logic          s_done;
  logic [DW-1:0] s_rdata;
  logic          m_valid, m_write, m_lock;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata;
  logic          m_ack = 1'b0;
  logic [DW-1:0] m_rdata = '0;

  always #10 clk = ~clk;  // 50 MHz

  bitalias_rmw u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_write(s_write), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_done(s_done), .s_rdata(s_rdata),
    .m_valid(m_valid), .m_write(m_write), .m_lock(m_lock), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int lat = 0, wcnt = 0;
  logic [DW-1:0] mem [16];
  logic [DW-1:0] expw [NW];
  int log_n = 0;
  logic          log_wr [4];
  logic          log_lk [4];
  logic [AW-1:0] log_ad [4];

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // backing memory model with programmable acknowledge latency
  always @(negedge clk) begin
    if (m_ack) m_ack = 1'b0;
    else if (m_valid) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        m_ack = 1'b1;
        m_rdata = mem[m_addr[5:2]];
        if (m_write) mem[m_addr[5:2]] = m_wdata;
        if (log_n < 4) begin
          log_wr[log_n] = m_write;
          log_lk[log_n] = m_lock;
          log_ad[log_n] = m_addr;
        end
        log_n++;
      end else wcnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic req(input logic wr, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, output logic [DW-1:0] rd);
    @(negedge clk);
    log_n = 0;
    s_valid = 1'b1; s_write = wr; s_addr = a; s_wdata = d;
    do @(negedge clk); while (!s_done);
    rd = s_rdata;
    s_valid = 1'b0; s_write = 1'b0;
    @(negedge clk);
    chk(s_done == 1'b0, "R7 done lasts one cycle", 32'(s_done), 0);
  endtask

  function automatic logic [AW-1:0] alias_addr(input int w, input int b);
    return AW'(32'h2000 + (w * DW + b) * 4);
  endfunction

  logic [DW-1:0] rd;

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h1357_9BDF * (i + 1);
    for (int i = 0; i < NW; i++) expw[i] = 32'h1357_9BDF * (i + 1);

    repeat (3) @(negedge clk);
    chk(m_valid == 0, "R8 no request in reset", 32'(m_valid), 0);
    chk(m_lock == 0, "R8 no lock in reset", 32'(m_lock), 0);
    chk(s_done == 0, "R8 no done in reset", 32'(s_done), 0);
    rst_n = 1'b1;

    // R6: plain write then read of backing word 3, and a word outside it
    req(1'b1, 16'h000C, 32'hCAFE_F00D, rd);
    expw[3] = 32'hCAFE_F00D;
    chk(mem[3] == 32'hCAFE_F00D, "R6 pass write data", mem[3], 32'hCAFE_F00D);
    chk(log_n == 1 && log_wr[0] && !log_lk[0] && log_ad[0] == 16'h000C,
        "R6 pass write single unlocked", 32'(log_n), 1);
    lat = 2;
    req(1'b0, 16'h000C, 32'h0, rd);
    chk(rd == 32'hCAFE_F00D, "R6 pass read data", rd, 32'hCAFE_F00D);
    req(1'b0, 16'h0030, 32'h0, rd);
    chk(rd == mem[12], "R6 pass read outside backing", rd, mem[12]);
    chk(log_n == 1 && !log_wr[0] && !log_lk[0], "R6 pass read unlocked",
        32'(log_n), 1);

    // full sweep of every alias word
    for (int w = 0; w < NW; w++) begin
      for (int b = 0; b < DW; b++) begin
        lat = (w + b) % 3;
        // R2: set, upper data bits are junk
        req(1'b1, alias_addr(w, b), (32'(b * 77 + w) << 1) | 32'h1, rd);
        expw[w] = expw[w] | (32'h1 << b);
        chk(mem[w] == expw[w], "R2 set bit R1 map", mem[w], expw[w]);
        chk(log_n == 2 && !log_wr[0] && log_wr[1],
            "R4 read then write", 32'(log_n), 2);
        chk(log_lk[0] && log_lk[1], "R4 lock on both",
            {30'd0, log_lk[1], log_lk[0]}, 3);
        chk(log_ad[0] == AW'(w * 4) && log_ad[1] == AW'(w * 4),
            "R1 backing address", 32'(log_ad[1]), 32'(w * 4));
        // R5: alias read returns 1 zero-extended
        req(1'b0, alias_addr(w, b), 32'hFFFF_FFFF, rd);
        chk(rd == 32'h1, "R5 alias read set bit", rd, 1);
        chk(log_n == 1 && !log_wr[0] && !log_lk[0], "R5 single unlocked read",
            32'(log_n), 1);
        if (b % 3 == 0) begin
          // R3: clear, bit 0 low, upper bits set
          req(1'b1, alias_addr(w, b), 32'hFFFF_FFFE ^ (32'(b) << 4), rd);
          expw[w] = expw[w] & ~(32'h1 << b);
          chk(mem[w] == expw[w], "R3 clear bit", mem[w], expw[w]);
          req(1'b0, alias_addr(w, b), 32'h0, rd);
          chk(rd == 32'h0, "R5 alias read cleared bit", rd, 0);
        end
      end
    end

    // R6: direct reads see all bits at once
    for (int w = 0; w < NW; w++) begin
      req(1'b0, AW'(w * 4), 32'h0, rd);
      chk(rd == expw[w], "R6 direct word after sweep", rd, expw[w]);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule